// File: doc/BRIEF.md
# Display Bridge Power-Up Sequencer

This block drives the bring-up of an external bridge that turns a parallel pixel stream into a serial display link. It works through a simple register master that it shares with the rest of the chip. A single `start` pulse sets off a fixed order of steps:

1. Pulse the bridge's reset pin and wait for it to settle.
2. Optionally read back two identity registers.
3. Program the video timing, pixel format and lane count.
4. Put the link in low-power configuration.
5. Set up the PLL and wait for it to lock.
6. Send two panel commands (leave sleep, then display on), each followed by a programmable wait in milliseconds.
7. Switch the data lanes to high speed and enable the video pipe.

The sequence ends in `done` or `error`.

The timing fields, PLL word and divider code are computed elsewhere and held steady on the inputs while the sequence runs. All waits are counted in system clock cycles, derived from the `CLK_HZ` parameter. Each register access is one request on the register master. A request holds its address and data until the master acknowledges it.

Top module: `bridge_seq`

## Requirements
- R1: After `start` in idle, `bridge_rst_n` goes low for exactly 10 ms of clock cycles, then stays high for at least 10 ms (at most 3 cycles more) before the first register access. No access is made while it is low.
- R2: With `readback_en` set, the first two accesses are reads of 0xB0 and then 0xB7. A value other than 0x2828 from 0xB0, or other than 0x0301 from 0xB7, ends the run in `error` with no further access. With `readback_en` clear, both reads are skipped.
- R3: Register 0xB1 gets {vsync width, hsync width}. Register 0xB2 gets {vsync+v_back, hsync+h_back}, each byte sum truncated to 8 bits. Register 0xB3 gets {v_front, h_front}. The vertical value is in bits 15:8 and the horizontal value in bits 7:0.
- R4: Register 0xB4 gets the active width and 0xB5 the active height, written after 0xB3.
- R5: Register 0xB6 gets 0x0008 OR a format code: 16 bpp → 0, 18 bpp packed → 1, 18 bpp loose → 2, 24 bpp → 3. Any other depth ends in `error` before 0xB6 is written.
- R6: Register 0xDE gets the lane count minus one.
- R7: The first write of 0xB7 is 0x0342, or 0x0362 when `pclk_ref` is set. The bits are: bit 9 end-of-transmission packet, bit 8 checksum off, bit 6 command-only, bit 1 clock lane high speed, bit 5 pixel clock as PLL reference.
- R8: The next writes, in order, are 0xBA ← PLL word, 0xB8 ← 0, 0xBB ← divider code, and 0xB9 ← 1. At least 500 µs (at most 4 cycles more) then pass before the next access.
- R9: Each panel command is 0xBC ← 1 followed by 0xBF ← code: first 0x11, then 0x29. Each is followed by its own wait of `dly_sleep_ms` or `dly_on_ms` milliseconds, at most 4 cycles more.
- R10: The last access writes 0xB7 with the first value OR 0x0009. `done` then rises and `busy` falls.
- R11: `bus_req` stays high, with address, data and direction stable, until `bus_ack`. It drops in the cycle after the acknowledge.
- R12: After reset the block is idle with `bridge_rst_n` high and `busy`, `done` and `error` low. `done` and `error` are never high together, and both hold until the next `start`. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up sequence (ignored while busy) |
| readback_en | input | 1 | Perform the identity read-back |
| pclk_ref | input | 1 | Pixel clock is the PLL reference |
| hsync_w | input | 8 | Horizontal sync width |
| vsync_w | input | 8 | Vertical sync width |
| h_back | input | 8 | Left (horizontal back) porch |
| v_back | input | 8 | Upper (vertical back) porch |
| h_front | input | 8 | Right (horizontal front) porch |
| v_front | input | 8 | Lower (vertical front) porch |
| h_active | input | 16 | Active width |
| v_active | input | 16 | Active height |
| depth | input | 5 | Colour depth in bits per pixel |
| loose_pack | input | 1 | Loose packing for 18 bpp |
| lanes | input | 3 | Data lane count (1 to 4) |
| pll_word | input | 16 | PLL configuration word |
| lp_div | input | 6 | Low-power clock divider code |
| dly_sleep_ms | input | DLY_W | Wait after the leave-sleep command, ms |
| dly_on_ms | input | DLY_W | Wait after the display-on command, ms |
| bus_ack | input | 1 | Register master accepted the request |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |
| bus_req | output | 1 | Register access request |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 16 | Write data (zero for reads) |
| bridge_rst_n | output | 1 | Bridge reset pin, active low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed |
| error | output | 1 | Sequence aborted |

## Verification
The checks assume the register master acknowledges only a pending request, with a one-cycle `bus_ack` pulse. They also assume every configuration input stays constant from `start` until `done` or `error`. The bench's responder acknowledges after a rotating latency of one to three cycles and always clears the pulse on the following cycle. It changes the configuration only while the block is idle. It does raise a second `start` partway through a run, on purpose, to show that the pulse has no effect.

// File: rtl/bridge_seq_pkg.sv
package bridge_seq_pkg;
  localparam int STEP_W = 5;
  localparam int REG_W  = 16;
  localparam int ADR_W  = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_RLO, S_RHI, S_STEP, S_XFER, S_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    W_NONE, W_LOCK, W_SLEEP, W_ON
  } wait_t;

  localparam logic [STEP_W-1:0] STEP_FIRST_WR = 5'd2;

  localparam logic [REG_W-1:0] ID_VAL   = 16'h2828;
  localparam logic [REG_W-1:0] CFG_RST  = 16'h0301;
  localparam logic [REG_W-1:0] CFG_BASE = 16'h0342;
  localparam logic [REG_W-1:0] CFG_PCLK = 16'h0020;
  localparam logic [REG_W-1:0] CFG_RUN  = 16'h0009;
  localparam logic [REG_W-1:0] CMD_WAKE = 16'h0011;
  localparam logic [REG_W-1:0] CMD_SHOW = 16'h0029;
endpackage

// File: rtl/bridge_seq_timer.sv
module bridge_seq_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/bridge_seq_steps.sv
module bridge_seq_steps
  import bridge_seq_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic              pclk_ref,
  input  logic [7:0]        hsync_w,
  input  logic [7:0]        vsync_w,
  input  logic [7:0]        h_back,
  input  logic [7:0]        v_back,
  input  logic [7:0]        h_front,
  input  logic [7:0]        v_front,
  input  logic [15:0]       h_active,
  input  logic [15:0]       v_active,
  input  logic [4:0]        depth,
  input  logic              loose_pack,
  input  logic [2:0]        lanes,
  input  logic [15:0]       pll_word,
  input  logic [5:0]        lp_div,
  output logic              op_wr,
  output logic [ADR_W-1:0]  op_addr,
  output logic [REG_W-1:0]  op_data,
  output logic [REG_W-1:0]  op_expect,
  output logic              op_bad,
  output wait_t             op_wait,
  output logic              op_last
);
  logic [1:0]       fmt;
  logic             fmt_ok;
  logic [7:0]       v_sum, h_sum;
  logic [REG_W-1:0] cfg_first;

  assign v_sum     = vsync_w + v_back;
  assign h_sum     = hsync_w + h_back;
  assign cfg_first = CFG_BASE | (pclk_ref ? CFG_PCLK : '0);

  always_comb begin
    fmt_ok = 1'b1;
    fmt    = 2'd0;
    case (depth)
      5'd16:   fmt = 2'd0;
      5'd18:   fmt = loose_pack ? 2'd2 : 2'd1;
      5'd24:   fmt = 2'd3;
      default: fmt_ok = 1'b0;
    endcase
  end

  always_comb begin
    op_wr     = 1'b1;
    op_addr   = 8'h00;
    op_data   = '0;
    op_expect = '0;
    op_bad    = 1'b0;
    op_wait   = W_NONE;
    op_last   = 1'b0;
    case (step)
      5'd0:  begin op_wr = 1'b0; op_addr = 8'hB0; op_expect = ID_VAL;  end
      5'd1:  begin op_wr = 1'b0; op_addr = 8'hB7; op_expect = CFG_RST; end
      5'd2:  begin op_addr = 8'hB1; op_data = {vsync_w, hsync_w}; end
      5'd3:  begin op_addr = 8'hB2; op_data = {v_sum, h_sum}; end
      5'd4:  begin op_addr = 8'hB3; op_data = {v_front, h_front}; end
      5'd5:  begin op_addr = 8'hB4; op_data = h_active; end
      5'd6:  begin op_addr = 8'hB5; op_data = v_active; end
      5'd7:  begin op_addr = 8'hB6; op_data = {12'h000, 2'b10, fmt}; op_bad = !fmt_ok; end
      5'd8:  begin op_addr = 8'hDE; op_data = 16'(lanes - 3'd1); end
      5'd9:  begin op_addr = 8'hB7; op_data = cfg_first; end
      5'd10: begin op_addr = 8'hBA; op_data = pll_word; end
      5'd11: begin op_addr = 8'hB8; op_data = '0; end
      5'd12: begin op_addr = 8'hBB; op_data = {10'h000, lp_div}; end
      5'd13: begin op_addr = 8'hB9; op_data = 16'h0001; op_wait = W_LOCK; end
      5'd14: begin op_addr = 8'hBC; op_data = 16'h0001; end
      5'd15: begin op_addr = 8'hBF; op_data = CMD_WAKE; op_wait = W_SLEEP; end
      5'd16: begin op_addr = 8'hBC; op_data = 16'h0001; end
      5'd17: begin op_addr = 8'hBF; op_data = CMD_SHOW; op_wait = W_ON; end
      5'd18: begin op_addr = 8'hB7; op_data = cfg_first | CFG_RUN; op_last = 1'b1; end
      default: op_last = 1'b1;
    endcase
  end
endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
  import bridge_seq_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000,
  parameter int TW     = 32,
  parameter int DLY_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             readback_en,
  input  logic             pclk_ref,
  input  logic [7:0]       hsync_w,
  input  logic [7:0]       vsync_w,
  input  logic [7:0]       h_back,
  input  logic [7:0]       v_back,
  input  logic [7:0]       h_front,
  input  logic [7:0]       v_front,
  input  logic [15:0]      h_active,
  input  logic [15:0]      v_active,
  input  logic [4:0]       depth,
  input  logic             loose_pack,
  input  logic [2:0]       lanes,
  input  logic [15:0]      pll_word,
  input  logic [5:0]       lp_div,
  input  logic [DLY_W-1:0] dly_sleep_ms,
  input  logic [DLY_W-1:0] dly_on_ms,
  input  logic             bus_ack,
  input  logic [15:0]      bus_rdata,
  output logic             bus_req,
  output logic             bus_wr,
  output logic [7:0]       bus_addr,
  output logic [15:0]      bus_wdata,
  output logic             bridge_rst_n,
  output logic             busy,
  output logic             done,
  output logic             error
);
  localparam int CYC_MS   = CLK_HZ / 1000;
  localparam int RST_CYC  = 10 * CYC_MS;
  localparam int LOCK_CYC = CLK_HZ / 2000;
  localparam logic [TW-1:0] CYC_MS_W = TW'(CYC_MS);
  localparam logic [TW-1:0] RST_M1   = TW'(RST_CYC - 1);
  localparam logic [TW-1:0] LOCK_M1  = TW'(LOCK_CYC - 1);

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic              op_wr, op_bad, op_last;
  logic [ADR_W-1:0]  op_addr;
  logic [REG_W-1:0]  op_data, op_expect;
  wait_t             op_wait;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val, wait_val;

  function automatic logic [TW-1:0] ms_m1(input logic [DLY_W-1:0] ms);
    logic [TW-1:0] prod;
    prod = TW'(ms) * CYC_MS_W;
    return (prod == '0) ? '0 : prod - 1'b1;
  endfunction

  bridge_seq_steps u_steps (
    .step(step), .pclk_ref(pclk_ref),
    .hsync_w(hsync_w), .vsync_w(vsync_w), .h_back(h_back), .v_back(v_back),
    .h_front(h_front), .v_front(v_front), .h_active(h_active), .v_active(v_active),
    .depth(depth), .loose_pack(loose_pack), .lanes(lanes),
    .pll_word(pll_word), .lp_div(lp_div),
    .op_wr(op_wr), .op_addr(op_addr), .op_data(op_data), .op_expect(op_expect),
    .op_bad(op_bad), .op_wait(op_wait), .op_last(op_last)
  );

  bridge_seq_timer #(.CW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  always_comb begin
    case (op_wait)
      W_SLEEP: wait_val = ms_m1(dly_sleep_ms);
      W_ON:    wait_val = ms_m1(dly_on_ms);
      default: wait_val = LOCK_M1;
    endcase
  end

  // timer loads on the same edge as the state change that starts a wait
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = RST_M1;
    case (state)
      S_IDLE:  tmr_load = start;
      S_RLO:   tmr_load = tmr_zero;
      S_XFER: begin
        tmr_load = bus_ack && (op_wait != W_NONE) && !op_last;
        tmr_val  = wait_val;
      end
      default: tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      step         <= '0;
      bus_req      <= 1'b0;
      bus_wr       <= 1'b0;
      bus_addr     <= '0;
      bus_wdata    <= '0;
      bridge_rst_n <= 1'b1;
      busy         <= 1'b0;
      done         <= 1'b0;
      error        <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          bridge_rst_n <= 1'b0;
          busy         <= 1'b1;
          done         <= 1'b0;
          error        <= 1'b0;
          state        <= S_RLO;
        end
        S_RLO: if (tmr_zero) begin
          bridge_rst_n <= 1'b1;
          state        <= S_RHI;
        end
        S_RHI: if (tmr_zero) begin
          step  <= readback_en ? '0 : STEP_FIRST_WR;
          state <= S_STEP;
        end
        S_STEP: begin
          if (op_bad) begin
            error <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            bus_req   <= 1'b1;
            bus_wr    <= op_wr;
            bus_addr  <= op_addr;
            bus_wdata <= op_data;
            state     <= S_XFER;
          end
        end
        S_XFER: if (bus_ack) begin
          bus_req <= 1'b0;
          if (!op_wr && (bus_rdata != op_expect)) begin
            error <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else if (op_last) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            step  <= step + 1'b1;
            state <= (op_wait != W_NONE) ? S_WAIT : S_STEP;
          end
        end
        S_WAIT: if (tmr_zero) state <= S_STEP;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bridge_seq_chk.sv
module bridge_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        error,
  input logic        bridge_rst_n,
  input logic        bus_req,
  input logic        bus_ack,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [15:0] bus_wdata
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wr));

  // R11
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req);

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bridge_rst_n |-> !bus_req);

  // R12
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !error);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !bus_req);

  // R5
  fmt_word_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_wr && bus_addr == 8'hB6 |-> bus_wdata[15:2] == 14'h0002);

  // R10
  run_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_wr && bus_addr == 8'hB7 && bus_wdata[0] |-> bus_wdata[3] && bus_wdata[9]);

  // R12
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    busy && start && bridge_rst_n |=> bridge_rst_n);
endmodule

bind bridge_seq bridge_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .error(error),
  .bridge_rst_n(bridge_rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/bridge_seq_tb.sv
module bridge_seq_tb;
  localparam int CLK_HZ = 100_000;
  localparam int CPM    = CLK_HZ / 1000;   // cycles per ms
  localparam int RSTC   = 10 * CPM;        // 10 ms
  localparam int LOCKC  = CLK_HZ / 2000;   // 500 us

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        start = 0, readback_en = 0, pclk_ref = 0, loose_pack = 0;
  logic [7:0]  hsync_w = 0, vsync_w = 0, h_back = 0, v_back = 0, h_front = 0, v_front = 0;
  logic [15:0] h_active = 0, v_active = 0, pll_word = 0;
  logic [4:0]  depth = 5'd24;
  logic [2:0]  lanes = 3'd1;
  logic [5:0]  lp_div = 0;
  logic [7:0]  dly_sleep_ms = 0, dly_on_ms = 0;
  logic        bus_ack = 0;
  logic [15:0] bus_rdata = 0;
  logic        bus_req, bus_wr, bridge_rst_n, busy, done, error;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;

  bridge_seq #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst(rst), .start(start), .readback_en(readback_en), .pclk_ref(pclk_ref),
    .hsync_w(hsync_w), .vsync_w(vsync_w), .h_back(h_back), .v_back(v_back),
    .h_front(h_front), .v_front(v_front), .h_active(h_active), .v_active(v_active),
    .depth(depth), .loose_pack(loose_pack), .lanes(lanes), .pll_word(pll_word),
    .lp_div(lp_div), .dly_sleep_ms(dly_sleep_ms), .dly_on_ms(dly_on_ms),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bridge_rst_n(bridge_rst_n),
    .busy(busy), .done(done), .error(error)
  );

  int checks = 0, fails = 0;
  logic [15:0] id_val = 16'h2828, cfg_val = 16'h0301;
  logic [24:0] exp_q[$], got_q[$];
  string       tag_q[$];
  bit          exp_err;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  // per-clock monitor and register-master model
  int  cyc = 0, fall_cnt = 0, low_start = 0, rise_cyc = 0, last_ack = 0, lat = 0, seed = 0;
  bit  first_req = 1, prev_req = 0, prev_rstn = 1;
  logic [7:0]  last_addr = 0, seen_addr = 0;
  logic [15:0] last_data = 0, seen_data = 0;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        if (prev_rstn && !bridge_rst_n) begin fall_cnt++; low_start = cyc; end
        if (!prev_rstn && bridge_rst_n) begin
          chk("R1 reset low width", cyc - low_start, RSTC);
          rise_cyc = cyc;
        end
        if (bus_req && !prev_req) begin
          seen_addr = bus_addr; seen_data = bus_wdata;
          if (first_req) begin
            first_req = 0;
            chk_rng("R1 settle before first access", cyc - rise_cyc, RSTC, RSTC + 3);
          end else if (last_addr == 8'hB9)
            chk_rng("R8 lock wait", cyc - last_ack, LOCKC, LOCKC + 4);
          else if (last_addr == 8'hBF && last_data == 16'h0011)
            chk_rng("R9 sleep wait", cyc - last_ack, int'(dly_sleep_ms) * CPM, int'(dly_sleep_ms) * CPM + 4);
          else if (last_addr == 8'hBF && last_data == 16'h0029)
            chk_rng("R9 on wait", cyc - last_ack, int'(dly_on_ms) * CPM, int'(dly_on_ms) * CPM + 4);
        end
        prev_req  = bus_req;
        prev_rstn = bridge_rst_n;
        if (bus_ack) bus_ack = 0;
        else if (bus_req) begin
          if (lat == 0) begin
            chk("R11 request held", {bus_addr, bus_wdata}, {seen_addr, seen_data});
            bus_rdata = (bus_addr == 8'hB0) ? id_val : (bus_addr == 8'hB7) ? cfg_val : 16'h0;
            bus_ack   = 1;
            got_q.push_back({bus_wr, bus_addr, bus_wr ? bus_wdata : 16'h0});
            last_ack  = cyc; last_addr = bus_addr; last_data = bus_wdata;
            seed++;
            lat = seed % 3;
          end else lat--;
        end
      end
    end
  end

  task automatic push(input string tag, input bit wr, input logic [7:0] a, input logic [15:0] d);
    exp_q.push_back({wr, a, d});
    tag_q.push_back(tag);
  endtask

  task automatic build_exp();
    logic [15:0] cfg;
    logic [1:0]  code;
    bit          ok;
    exp_q.delete(); tag_q.delete(); exp_err = 0;
    if (readback_en) begin
      push("R2 read id", 0, 8'hB0, 0);
      if (id_val != 16'h2828) begin exp_err = 1; return; end
      push("R2 read cfg", 0, 8'hB7, 0);
      if (cfg_val != 16'h0301) begin exp_err = 1; return; end
    end
    push("R3 sync widths", 1, 8'hB1, {vsync_w, hsync_w});
    push("R3 back porches", 1, 8'hB2, {8'(vsync_w + v_back), 8'(hsync_w + h_back)});
    push("R3 front porches", 1, 8'hB3, {v_front, h_front});
    push("R4 width", 1, 8'hB4, h_active);
    push("R4 height", 1, 8'hB5, v_active);
    ok = 1; code = 0;
    if (depth == 16) code = 0;
    else if (depth == 18) code = loose_pack ? 2 : 1;
    else if (depth == 24) code = 3;
    else ok = 0;
    if (!ok) begin exp_err = 1; return; end
    push("R5 format", 1, 8'hB6, 16'h0008 | 16'(code));
    push("R6 lanes", 1, 8'hDE, 16'(lanes) - 16'd1);
    cfg = 16'h0342 | (pclk_ref ? 16'h0020 : 16'h0);
    push("R7 low-power cfg", 1, 8'hB7, cfg);
    push("R8 pll word", 1, 8'hBA, pll_word);
    push("R8 vc zero", 1, 8'hB8, 16'h0);
    push("R8 divider", 1, 8'hBB, 16'(lp_div));
    push("R8 pll enable", 1, 8'hB9, 16'h1);
    push("R9 size 1", 1, 8'hBC, 16'h1);
    push("R9 wake cmd", 1, 8'hBF, 16'h11);
    push("R9 size 1", 1, 8'hBC, 16'h1);
    push("R9 show cmd", 1, 8'hBF, 16'h29);
    push("R10 run cfg", 1, 8'hB7, cfg | 16'h0009);
  endtask

  task automatic run_case(input string name, input bit restart);
    int n;
    build_exp();
    got_q.delete();
    fall_cnt = 0; first_req = 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (restart) begin
      repeat (1500) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    n = 0;
    while (!(done || error) && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk({"R12 done flag ", name}, done, !exp_err);
    chk({"R12 error flag ", name}, error, exp_err);
    chk({"R10 busy low ", name}, busy, 0);
    chk({"R12 single reset pulse ", name}, fall_cnt, 1);
    chk({"R2 access count ", name}, got_q.size(), exp_q.size());
    foreach (exp_q[i])
      if (i < got_q.size()) chk({tag_q[i], " ", name}, got_q[i], exp_q[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R12 reset pin idle", bridge_rst_n, 1);
    chk("R12 reset busy", busy, 0);
    chk("R12 reset done", done, 0);
    chk("R12 reset error", error, 0);

    // 24 bpp, read-back on, crystal reference, 4 lanes
    readback_en = 1; pclk_ref = 0; depth = 24; loose_pack = 0; lanes = 4;
    hsync_w = 8'd10; vsync_w = 8'd3; h_back = 8'd40; v_back = 8'd12;
    h_front = 8'd20; v_front = 8'd7; h_active = 16'd800; v_active = 16'd480;
    pll_word = 16'h8123; lp_div = 6'd5; dly_sleep_ms = 2; dly_on_ms = 3;
    run_case("A", 0);

    // 18 bpp loose, no read-back, pixel-clock reference, byte-sum wrap, restart ignored
    readback_en = 0; pclk_ref = 1; depth = 18; loose_pack = 1; lanes = 2;
    hsync_w = 8'hF0; vsync_w = 8'hC0; h_back = 8'h20; v_back = 8'h50;
    h_active = 16'd1280; v_active = 16'd720; dly_sleep_ms = 0; dly_on_ms = 1;
    run_case("B", 1);

    // 16 bpp, one lane
    readback_en = 1; pclk_ref = 0; depth = 16; loose_pack = 0; lanes = 1;
    pll_word = 16'h4F07; lp_div = 6'd63; dly_sleep_ms = 1; dly_on_ms = 0;
    run_case("C", 0);

    // 18 bpp packed, three lanes
    depth = 18; loose_pack = 0; lanes = 3;
    run_case("D", 0);

    // bad identity
    id_val = 16'h1234;
    run_case("E", 0);
    id_val = 16'h2828;

    // bad config read-back
    cfg_val = 16'h0300;
    run_case("F", 0);
    cfg_val = 16'h0301;

    // unsupported depth
    depth = 20;
    run_case("G", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule